// File: doc/BRIEF.md
# Phase Lock Status Monitor

This block watches a delay-tracking loop once it has settled. Each cycle it compares a 5-bit measured phase with a 5-bit target phase and keeps two flags: one that reports the loop as locked, and one that reports that an established lock has since been lost. The flags use hysteresis. Lock is dropped only when the error exceeds four steps, and it is regained only when the error is three steps or less. An error of exactly four steps leaves both flags as they are.

When lock drops, a configuration bit decides what happens next. With the bit clear, the loop keeps tracking and the monitor simply reports the loss. With the bit set, the monitor issues a one-cycle request for the controller to restart its full search. A separate capture strobe latches the delay value and target phase currently in use, so that they can be read back later while the loop keeps running.

Top module: `phase_lock_monitor`

## Requirements
- R1: While `rst_n` is low, `locked`, `lost`, `restart_req`, `snap_delay` and `snap_target` are all zero.
- R2: In the cycle after `track_en` goes from 0 to 1, `locked` is 1 and `lost` is 0, whatever the phase error is.
- R3: The phase error is the absolute difference of the two 5-bit values, with no wrap-around, so 0 against 31 is an error of 31. While tracking and locked, an error of 5 or more clears `locked` in the next cycle.
- R4: When `locked` falls because of the error, `lost` rises in the same cycle. `lost` never rises unless `locked` was 1 in the cycle before.
- R5: While tracking and unlocked, an error of 3 or less sets `locked` and clears `lost` in the next cycle.
- R6: While tracking, an error of exactly 4 leaves both `locked` and `lost` unchanged.
- R7: `restart_req` is high for exactly one cycle, the cycle in which `locked` falls, and only when `restart_on_loss` was 1 at the drop. It is never high when `restart_on_loss` is 0.
- R8: A cycle with `search_start` high clears both `locked` and `lost` in the next cycle. This takes priority over every other update.
- R9: While `track_en` is low, the phase inputs have no effect: `locked` and `lost` hold.
- R10: A cycle with `snap_req` high loads `snap_delay` from `delay_in` and `snap_target` from `target_phase` at the next edge. With `snap_req` low, both hold.
- R11: `locked` and `lost` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| track_en | input | 1 | Delay controller is in track mode |
| search_start | input | 1 | A new search is starting |
| meas_phase | input | 5 | Measured phase |
| target_phase | input | 5 | Target phase |
| restart_on_loss | input | 1 | 1 requests a search restart when lock is lost |
| snap_req | input | 1 | Capture delay and target for read-back |
| delay_in | input | 9 | Delay setting currently in use |
| locked | output | 1 | Lock flag |
| lost | output | 1 | Lock-lost flag |
| restart_req | output | 1 | One-cycle search restart request |
| snap_delay | output | 9 | Captured delay |
| snap_target | output | 5 | Captured target phase |

## Verification
The in-module assertions check on every cycle that the two flags are never both set, that a large error drops lock, that a four-step error holds the state, that a search start clears both flags, that the flags freeze while tracking is off, and that a restart request is a lone pulse that always comes with a drop. The bench scenarios are the only place where the hysteresis is shown end to end: keeping lock at four steps, dropping at five, staying unlocked at four and relocking at three. They also cover the wrap-free error at the 0 and 31 extremes, the lock taken when tracking begins, and that a capture holds its values after the inputs move on.

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor #(
  parameter int PW = 5,
  parameter int DW = 9,
  parameter int DROP_ABOVE = 4,
  parameter int GAIN_AT_MOST = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          track_en,
  input  logic          search_start,
  input  logic [PW-1:0] meas_phase,
  input  logic [PW-1:0] target_phase,
  input  logic          restart_on_loss,
  input  logic          snap_req,
  input  logic [DW-1:0] delay_in,
  output logic          locked,
  output logic          lost,
  output logic          restart_req,
  output logic [DW-1:0] snap_delay,
  output logic [PW-1:0] snap_target
);

  logic          track_q;
  logic [PW-1:0] err;
  logic          enter, tracking, too_far, close_in, drop;

  assign err      = (meas_phase >= target_phase) ? meas_phase - target_phase
                                                 : target_phase - meas_phase;
  assign enter    = track_en && !track_q;
  assign tracking = track_en && track_q;
  assign too_far  = 32'(err) > DROP_ABOVE;
  assign close_in = 32'(err) <= GAIN_AT_MOST;
  assign drop     = !search_start && tracking && locked && too_far;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      track_q     <= 1'b0;
      locked      <= 1'b0;
      lost        <= 1'b0;
      restart_req <= 1'b0;
    end else begin
      track_q     <= track_en;
      restart_req <= drop && restart_on_loss;
      if (search_start) begin
        locked <= 1'b0;
        lost   <= 1'b0;
      end else if (enter) begin
        locked <= 1'b1;
        lost   <= 1'b0;
      end else if (drop) begin
        locked <= 1'b0;
        lost   <= 1'b1;
      end else if (tracking && !locked && close_in) begin
        locked <= 1'b1;
        lost   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_delay  <= '0;
      snap_target <= '0;
    end else if (snap_req) begin
      snap_delay  <= delay_in;
      snap_target <= target_phase;
    end
  end

  assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && track_q && !search_start && locked && too_far) |=> !locked);

  assert_lost_after_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> $past(locked));

  assert_hold_at_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && track_q && !search_start && 32'(err) == DROP_ABOVE)
      |=> ($stable(locked) && $stable(lost)));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);

  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> (!locked && $past(locked) && $past(restart_on_loss)));

  assert_search_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    search_start |=> (!locked && !lost));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!track_en && !search_start) |=> ($stable(locked) && $stable(lost)));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && lost));

endmodule

// File: tb/tb_phase_lock_monitor.sv
module tb_phase_lock_monitor;
  logic       clk = 1'b0;
  logic       rst_n, track_en, search_start, restart_on_loss, snap_req;
  logic [4:0] meas_phase, target_phase;
  logic [8:0] delay_in;
  logic       locked, lost, restart_req;
  logic [8:0] snap_delay;
  logic [4:0] snap_target;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  phase_lock_monitor dut (
    .clk(clk), .rst_n(rst_n), .track_en(track_en), .search_start(search_start),
    .meas_phase(meas_phase), .target_phase(target_phase),
    .restart_on_loss(restart_on_loss), .snap_req(snap_req), .delay_in(delay_in),
    .locked(locked), .lost(lost), .restart_req(restart_req),
    .snap_delay(snap_delay), .snap_target(snap_target)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic flags(input int l, input int s, input int r, input string tag);
    chk(int'(locked), l, {tag, " locked"});
    chk(int'(lost), s, {tag, " lost"});
    chk(int'(restart_req), r, {tag, " restart_req"});
  endtask

  task automatic t_reset();
    rst_n = 0; track_en = 0; search_start = 0; restart_on_loss = 0;
    snap_req = 0; meas_phase = 0; target_phase = 0; delay_in = 0;
    repeat (3) step();
    flags(0, 0, 0, "R1");
    chk(int'(snap_delay), 0, "R1 snap_delay");
    chk(int'(snap_target), 0, "R1 snap_target");
    rst_n = 1;
    step();
  endtask

  task automatic t_hysteresis();
    track_en = 1; target_phase = 10; meas_phase = 10; step();
    flags(1, 0, 0, "R2 enter");
    meas_phase = 14; step();
    flags(1, 0, 0, "R6 err4 locked");
    meas_phase = 15; step();
    flags(0, 1, 0, "R3 R4 R7 err5 drop");
    meas_phase = 6; step();
    flags(0, 1, 0, "R6 err4 unlocked");
    meas_phase = 13; step();
    flags(1, 0, 0, "R5 err3 regain");
  endtask

  task automatic t_restart();
    restart_on_loss = 1; meas_phase = 0; target_phase = 31; step();
    flags(0, 1, 1, "R3 R7 wrap drop");
    step();
    flags(0, 1, 0, "R7 pulse ends");
    meas_phase = 31; step();
    flags(1, 0, 0, "R5 relock");
    restart_on_loss = 0;
  endtask

  task automatic t_idle();
    track_en = 0; meas_phase = 5; target_phase = 25; step();
    step();
    flags(1, 0, 0, "R9 idle holds lock");
  endtask

  task automatic t_search();
    meas_phase = 0; target_phase = 20; track_en = 1; step();
    flags(1, 0, 0, "R2 enter ignores error");
    step();
    flags(0, 1, 0, "R4 drop");
    search_start = 1; step();
    flags(0, 0, 0, "R8 search clears");
    search_start = 0; track_en = 0; step();
    track_en = 1; meas_phase = 20; search_start = 1; step();
    flags(0, 0, 0, "R8 priority over entry");
    search_start = 0; track_en = 0; step();
  endtask

  task automatic t_snap();
    delay_in = 300; target_phase = 7; snap_req = 1; step();
    chk(int'(snap_delay), 300, "R10 snap_delay load");
    chk(int'(snap_target), 7, "R10 snap_target load");
    snap_req = 0; delay_in = 5; target_phase = 9; step();
    chk(int'(snap_delay), 300, "R10 snap_delay hold");
    chk(int'(snap_target), 7, "R10 snap_target hold");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=5000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_hysteresis();
    t_restart();
    t_idle();
    t_search();
    t_snap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule